// File: doc/BRIEF.md
# Touch Screen ADC Serial Port Model

This block is a synthesizable, device-side model of the digital serial port of a resistive touch screen converter. A host drives a chip-select (active low), a serial clock and a serial data line. The block waits for a high start bit and then collects a control byte. It hands the decoded input channel, result width, reference style and power-down selection to the surrounding logic. It then requests one sample from a parallel input and returns it on the serial data output.

The analog front end, the multiplexer and the conversion core stay outside. A neighbouring model supplies the 12-bit sample when the request strobe is high. All serial inputs are brought into the system clock domain through a configurable synchronizer and handled by edge detection, so the whole block runs on one clock.

A new start bit may arrive while the previous result is still being shifted out. This allows frames that repeat every 16 or every 15 serial clocks.

Top module: `touch_adc_port`

## Requirements
- R1: After reset, dout, busy, sample_req, pwr_on and all decoded field outputs are 0.
- R2: While no control byte is in progress, a low din on a rising serial clock edge is ignored; the first high din captured on a rising edge is the start bit.
- R3: The seven bits after the start bit, in arrival order, are chan_sel[2], chan_sel[1], chan_sel[0], short_mode, single_ref, pd_sel[1], pd_sel[0]; the field outputs change only when the seventh bit arrives.
- R4: busy and sample_req are high from the rising edge carrying the seventh control bit until the next rising edge; sample_in is captured at that next rising edge.
- R5: With short_mode 0, dout presents the 12 captured bits most significant first, one per falling edge, starting with the falling edge right after busy ends; dout is 0 at every other falling edge.
- R6: With short_mode 1, dout presents only sample bits 11 down to 4, most significant first, in the same slots, and then 0.
- R7: pwr_on goes to 1 when a start bit is captured; if pd_sel is 00, it returns to 0 when the sample is captured; for any other pd_sel value it stays 1.
- R8: While cs_n is high the port is idle: dout and busy are 0, a partly received control byte is discarded, a pending result is dropped, and the field outputs keep their last complete values.
- R9: A start bit captured while a result is still shifting out begins a new control byte without disturbing the bits of the older result, for frames 16 or 15 serial clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| cs_n | input | 1 | Serial chip select, active low |
| dclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| sample_in | input | SAMPLE_W | Parallel sample from the conversion model |
| dout | output | 1 | Serial result data |
| busy | output | 1 | High during the one-clock conversion slot |
| sample_req | output | 1 | Requests a sample on sample_in |
| chan_sel | output | 3 | Decoded input channel |
| short_mode | output | 1 | 1 selects the short (8-bit) result |
| single_ref | output | 1 | 1 selects single-ended reference, 0 ratiometric |
| pd_sel | output | 2 | Decoded power-down selection |
| pwr_on | output | 1 | Converter power indication |

## Verification
The bench builds the block with a 12-bit sample, an 8-bit short result and a two-stage input synchronizer. The serial clock runs at twelve system clocks per period, which leaves room for the synchronizer latency inside each half period. These values bring both result widths within reach, along with the 16- and 15-clock overlapped frames. Aborts by chip select, in the middle of a control byte and in the middle of a result, are also exercised.

// File: rtl/touch_adc_pkg.sv
package touch_adc_pkg;

   // Control byte fields, most significant field arrives first on the wire.
   typedef struct packed {
      logic [2:0] chan;
      logic       short_mode;
      logic       single_ref;
      logic [1:0] pd;
   } ctrl_fields_t;

   localparam int CTRL_BITS = $bits(ctrl_fields_t);
   localparam logic [1:0] PD_SLEEP_AFTER = 2'b00;

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_CTRL = 2'd1,
      CAP_BUSY = 2'd2
   } cap_state_e;

endpackage

// File: rtl/touch_adc_sync.sv
module touch_adc_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q_o = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/touch_adc_ctrl.sv
module touch_adc_ctrl
   import touch_adc_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         rise_i,
   input  logic         din_i,
   output ctrl_fields_t fields_o,
   output logic         busy_o,
   output logic         latch_o,
   output logic         pwr_o
);

   localparam int CNT_W = $clog2(CTRL_BITS);

   cap_state_e             state;
   logic [CNT_W-1:0]       cnt;
   logic [CTRL_BITS-2:0]   shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= CAP_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         fields_o <= '0;
         pwr_o    <= 1'b0;
      end else if (clr_i) begin
         state <= CAP_IDLE;
         cnt   <= '0;
      end else if (rise_i) begin
         case (state)
            CAP_IDLE: begin
               if (din_i) begin
                  state <= CAP_CTRL;
                  cnt   <= '0;
                  pwr_o <= 1'b1;
               end
            end
            CAP_CTRL: begin
               shreg <= {shreg[CTRL_BITS-3:0], din_i};
               if (cnt == CNT_W'(CTRL_BITS - 1)) begin
                  fields_o <= ctrl_fields_t'({shreg, din_i});
                  state    <= CAP_BUSY;
                  cnt      <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            CAP_BUSY: begin
               state <= CAP_IDLE;
               if (fields_o.pd == PD_SLEEP_AFTER) pwr_o <= 1'b0;
            end
            default: state <= CAP_IDLE;
         endcase
      end
   end

   assign busy_o  = (state == CAP_BUSY);
   assign latch_o = busy_o && rise_i && !clr_i;

   // R4: the conversion slot lasts a single serial clock
   assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && rise_i) |=> !busy_o);

   // R3: fields move only while the control byte is being collected
   assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != CAP_CTRL) |=> $stable(fields_o));

   // R7: a non-sleeping power selection never drops the power indication
   assert_pwr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_o && fields_o.pd != PD_SLEEP_AFTER) |=> pwr_o);

endmodule

// File: rtl/touch_adc_shift.sv
module touch_adc_shift #(
   parameter int SAMPLE_W = 12,
   parameter int SHORT_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                latch_i,
   input  logic                short_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                fall_i,
   output logic                dout_o
);

   localparam int CNT_W = $clog2(SAMPLE_W + 1);

   logic [SAMPLE_W-1:0] sreg;
   logic [SAMPLE_W-1:0] load_short;
   logic [CNT_W-1:0]    cnt;

   generate
      if (SHORT_W < SAMPLE_W) begin : g_trunc
         assign load_short = {sample_i[SAMPLE_W-1 -: SHORT_W], {(SAMPLE_W-SHORT_W){1'b0}}};
      end else begin : g_full
         assign load_short = sample_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg   <= '0;
         cnt    <= '0;
         dout_o <= 1'b0;
      end else if (clr_i) begin
         cnt    <= '0;
         dout_o <= 1'b0;
      end else if (latch_i) begin
         sreg <= short_i ? load_short : sample_i;
         cnt  <= short_i ? CNT_W'(SHORT_W) : CNT_W'(SAMPLE_W);
      end else if (fall_i) begin
         if (cnt != '0) begin
            dout_o <= sreg[SAMPLE_W-1];
            sreg   <= sreg << 1;
            cnt    <= cnt - 1'b1;
         end else begin
            dout_o <= 1'b0;
         end
      end
   end

   // R5: once the result is drained every falling edge gives a zero
   assert_zero_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && fall_i && !latch_i) |=> !dout_o);

   // R6: a short result loads exactly the short bit count
   assert_short_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_i && short_i && !clr_i) |=> (cnt == CNT_W'(SHORT_W)));

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(SAMPLE_W));

endmodule

// File: rtl/touch_adc_port.sv
module touch_adc_port
   import touch_adc_pkg::*;
#(
   parameter int SAMPLE_W    = 12,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                dclk,
   input  logic                din,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic                dout,
   output logic                busy,
   output logic                sample_req,
   output logic [2:0]          chan_sel,
   output logic                short_mode,
   output logic                single_ref,
   output logic [1:0]          pd_sel,
   output logic                pwr_on
);

   generate
      if (SHORT_W < 1 || SHORT_W > SAMPLE_W) begin : g_bad_short
         $error("SHORT_W must lie between 1 and SAMPLE_W");
      end
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("SAMPLE_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   logic [2:0]   sync_q;
   logic         s_cs_n, s_dclk, s_din;
   logic         dclk_d;
   logic         rise, fall;
   logic         busy_w, latch_w;
   ctrl_fields_t fields;

   touch_adc_sync #(
      .W      (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({cs_n, dclk, din}),
      .q_o  (sync_q)
   );

   assign {s_cs_n, s_dclk, s_din} = sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) dclk_d <= 1'b0;
      else        dclk_d <= s_dclk;
   end

   assign rise = s_dclk && !dclk_d && !s_cs_n;
   assign fall = !s_dclk && dclk_d && !s_cs_n;

   touch_adc_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (s_cs_n),
      .rise_i  (rise),
      .din_i   (s_din),
      .fields_o(fields),
      .busy_o  (busy_w),
      .latch_o (latch_w),
      .pwr_o   (pwr_on)
   );

   touch_adc_shift #(
      .SAMPLE_W(SAMPLE_W),
      .SHORT_W (SHORT_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (s_cs_n),
      .latch_i (latch_w),
      .short_i (fields.short_mode),
      .sample_i(sample_in),
      .fall_i  (fall),
      .dout_o  (dout)
   );

   assign busy       = busy_w;
   assign sample_req = busy_w;
   assign chan_sel   = fields.chan;
   assign short_mode = fields.short_mode;
   assign single_ref = fields.single_ref;
   assign pd_sel     = fields.pd;

   // R8: a deselected port drives nothing
   assert_cs_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_cs_n && $past(s_cs_n)) |-> (!dout && !busy));

endmodule

// File: tb/touch_adc_port_bench.sv
module touch_adc_port_bench;

   localparam int SW   = 12;
   localparam int HALF = 6;
   localparam int NC   = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          dclk = 1'b0;
   logic          din = 1'b0;
   logic [SW-1:0] sample_in = '0;
   logic          dout, busy, sample_req, short_mode, single_ref, pwr_on;
   logic [2:0]    chan_sel;
   logic [1:0]    pd_sel;

   always #5 clk = ~clk;

   touch_adc_port #(.SAMPLE_W(SW), .SHORT_W(8), .SYNC_STAGES(2)) u_touch_adc_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .din(din),
      .sample_in(sample_in), .dout(dout), .busy(busy), .sample_req(sample_req),
      .chan_sel(chan_sel), .short_mode(short_mode), .single_ref(single_ref),
      .pd_sel(pd_sel), .pwr_on(pwr_on)
   );

   typedef struct {
      bit       dv;
      bit       bz;
      bit       chk_fld;
      bit [6:0] fld;
      bit       chk_pwr;
      bit       pwr;
      string    tag;
   } exp_t;

   exp_t          ex_a [NC];
   bit            din_a [NC];
   bit [SW-1:0]   smp_a [NC];
   bit            smp_set [NC];
   int            seq_len;
   exp_t          q [$];
   event          smp_ev;
   int            checks = 0;
   int            errs = 0;
   bit            done = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic clear_seq(input string tag);
      for (int k = 0; k < NC; k++) begin
         ex_a[k].dv = 1'b0; ex_a[k].bz = 1'b0; ex_a[k].chk_fld = 1'b0;
         ex_a[k].fld = '0; ex_a[k].chk_pwr = 1'b0; ex_a[k].pwr = 1'b0;
         ex_a[k].tag = tag;
         din_a[k] = 1'b0; smp_a[k] = '0; smp_set[k] = 1'b0;
      end
      seq_len = 0;
   endtask

   // Expected stream of one frame whose start bit is on serial cycle s
   task automatic add_frame(input int s, input bit [6:0] ctl,
                            input bit [SW-1:0] smp, input string tag);
      int w;
      din_a[s] = 1'b1;
      for (int i = 0; i < 7; i++) din_a[s+1+i] = ctl[6-i];
      ex_a[s+8].bz      = 1'b1;
      ex_a[s+8].chk_fld = 1'b1;
      ex_a[s+8].fld     = ctl;
      ex_a[s+8].chk_pwr = 1'b1;
      ex_a[s+8].pwr     = 1'b1;
      smp_set[s+8]      = 1'b1;
      smp_a[s+8]        = smp;
      ex_a[s+9].chk_pwr = 1'b1;
      ex_a[s+9].pwr     = (ctl[1:0] != 2'b00);
      w = ctl[3] ? 8 : 12;
      for (int i = 0; i < w; i++) begin
         ex_a[s+9+i].dv  = smp[SW-1-i];
         ex_a[s+9+i].tag = tag;
      end
      if (s + w + 11 > seq_len) seq_len = s + w + 11;
   endtask

   // Driver: pushes the expectation of each serial cycle, then clocks it
   task automatic run_seq();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < seq_len; k++) begin
         din  = din_a[k];
         dclk = 1'b0;
         if (smp_set[k]) sample_in = smp_a[k];
         repeat (HALF) @(negedge clk);
         q.push_back(ex_a[k]);
         ->smp_ev;
         dclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      dclk = 1'b0;
      din  = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_release();
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(dout == 1'b0, "R8", "dout while deselected", dout, 0);
      chk(busy == 1'b0, "R8", "busy while deselected", busy, 0);
   endtask

   // Monitor: pops expectations as the design produces them
   initial begin
      forever begin
         @(smp_ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(dout == e.dv, e.tag, "dout", dout, e.dv);
            chk(busy == e.bz, "R4", "busy", busy, e.bz);
            chk(sample_req == e.bz, "R4", "sample_req", sample_req, e.bz);
            if (e.chk_fld)
               chk({chan_sel, short_mode, single_ref, pd_sel} == e.fld, "R3", "fields",
                   {chan_sel, short_mode, single_ref, pd_sel}, e.fld);
            if (e.chk_pwr)
               chk(pwr_on == e.pwr, "R7", "pwr_on", pwr_on, e.pwr);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state
      chk(dout == 1'b0, "R1", "dout", dout, 0);
      chk(busy == 1'b0 && sample_req == 1'b0, "R1", "busy/req", {busy, sample_req}, 0);
      chk({chan_sel, short_mode, single_ref, pd_sel} == 7'd0, "R1", "fields",
          {chan_sel, short_mode, single_ref, pd_sel}, 0);
      chk(pwr_on == 1'b0, "R1", "pwr_on", pwr_on, 0);

      // R2 and R5: leading zeros ignored, 12-bit result, sleep after
      clear_seq("R5");
      add_frame(3, 7'b101_0_1_00, 12'hA5C, "R5");
      for (int k = 0; k < 3; k++) ex_a[k].tag = "R2";
      run_seq();
      cs_release();

      // R6: short result, power kept on
      clear_seq("R6");
      add_frame(2, 7'b011_1_0_11, 12'h3C9, "R6");
      run_seq();
      cs_release();

      // R9: overlapped frames 16 and 15 serial clocks apart
      clear_seq("R9");
      add_frame(0,  7'b110_0_0_01, 12'hF0F, "R9");
      add_frame(16, 7'b001_1_1_10, 12'h9A5, "R9");
      add_frame(31, 7'b111_0_1_00, 12'h5A3, "R9");
      run_seq();
      cs_release();

      // R8: abort inside a control byte keeps the last fields
      clear_seq("R8");
      din_a[1] = 1'b1; din_a[2] = 1'b1; din_a[3] = 1'b1; din_a[4] = 1'b1;
      seq_len = 5;
      run_seq();
      cs_release();
      chk({chan_sel, short_mode, single_ref, pd_sel} == 7'b111_0_1_00, "R8", "fields kept",
          {chan_sel, short_mode, single_ref, pd_sel}, 7'b111_0_1_00);

      // R8: clean frame after the abort
      clear_seq("R8");
      add_frame(2, 7'b000_0_0_11, 12'h801, "R8");
      run_seq();
      cs_release();

      // R8: abort in the middle of a result, then nothing left to shift
      clear_seq("R8");
      add_frame(0, 7'b000_0_1_11, 12'hFFF, "R8");
      seq_len = 13;
      run_seq();
      cs_release();
      clear_seq("R8");
      seq_len = 6;
      run_seq();
      cs_release();

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule